// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block sits after a video sync slicer. It takes a clean, digital, active-low composite sync stream on the system clock. From it the block produces an active-low vertical sync pulse, an odd/even field flag and a flag that shows the sync input has gone dead. The input first passes through a two-flop synchronizer and an edge detector. An up/down integrator then tells broad vertical pulses apart from short line pulses. Once a broad pulse has been integrated, vertical timing starts on the first serration edge. If no serration edge arrives, a fallback timer starts it instead. After that, the vertical pulse times itself and no longer follows the input.

A free-running line-phase counter is pulled back into step by every pulse of horizontal-sync length. Equalizing and broad pulses do not move it. When vertical timing starts, the phase of the line decides whether the new field is odd or even. Every duration is a clock-cycle count derived from one parameter, `LINE_CYC` (clocks per scan line). This lets the block follow non-standard scan rates.

With `LINE_CYC` = 64, the derived counts are:

| Count | Formula | Value |
|---|---|---|
| Integrator threshold THR | LINE_CYC*3/16 | 12 |
| Shortest line pulse HS_MIN | LINE_CYC/16 | 4 |
| Fallback delay DEF | LINE_CYC*55/64 | 55 |
| Vertical width VS | LINE_CYC*230/64 | 230 |
| Loss limit LOS | VS + LINE_CYC | 294 |

Top module: `vsync_field_det`

## Requirements
- R1: After reset, `vsync_n` is 1, `field_odd` is 0 (even) and `signal_lost` is 0.
- R2: Low pulses shorter than THR clock cycles never start a vertical pulse. This holds for pulses of up to THR-1 cycles, for pulses spaced one line apart and for pulses spaced half a line apart.
- R3: The integrator arms once the input has been low for a net THR cycles. It counts up while the input is low and down while it is high. A rising input edge while armed drives `vsync_n` low exactly 3 clock edges after that edge is applied.
- R4: If no rising edge follows arming, `vsync_n` goes low THR+DEF+2 edges after the input falling edge that began the broad pulse.
- R5: `vsync_n` stays low for exactly VS cycles, whatever the input does meanwhile.
- R6: `field_odd` changes only on the edge that drives `vsync_n` low. At that edge it becomes 1 when the line phase is below LINE_CYC/4 or at or above 3*LINE_CYC/4, and 0 otherwise. Phase 0 is the cycle in which a line pulse's falling edge is seen after synchronization.
- R7: Only low pulses of length HS_MIN to THR-1 cycles re-align the line phase. Shorter (equalizing) and longer (broad) pulses leave it free-running.
- R8: `signal_lost` rises LOS+2 edges after the input falls, if the input stays low that long. It falls 3 edges after the input rises.
- R9: Broad pulses that arrive while `vsync_n` is low neither restart nor extend the vertical pulse. One vertical interval yields one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n_in | input | 1 | Sliced composite sync, active low, asynchronous |
| vsync_n | output | 1 | Self-timed vertical sync, active low |
| field_odd | output | 1 | 1 in odd fields, 0 in even fields |
| signal_lost | output | 1 | Input held low longer than LOS cycles |

## Verification
Each result has a fixed latency from the input edge that causes it:
- a serration-started vertical pulse falls 3 edges after the rising input edge;
- a fallback-started one falls THR+DEF+2 edges after the broad pulse's falling edge;
- the loss flag rises LOS+2 edges after a falling edge and clears 3 edges after the rise.

The bench drives the input on falling clock edges and counts rising edges. A monitor stamps the cycle in which each output change is first seen at a falling edge. Each check compares the difference between stamps with the expected latency, so every check is exact to the cycle rather than a tolerance window. Field and width results are read only after the vertical pulse has fully ended.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  typedef enum logic {
    FIELD_EVEN = 1'b0,
    FIELD_ODD  = 1'b1
  } field_e;

  // Odd when the vertical start lies within a quarter line of a line-pulse edge.
  function automatic field_e classify_phase(input int unsigned ph, input int unsigned line);
    if (ph < line / 4 || ph >= (3 * line) / 4) return FIELD_ODD;
    return FIELD_EVEN;
  endfunction

endpackage

// File: rtl/vfd_sync_edge.sv
module vfd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/vfd_integrator.sv
module vfd_integrator #(
  parameter int unsigned THR     = 12,
  parameter int unsigned DEF_CYC = 55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  input  logic vs_busy,
  output logic armed,
  output logic start
);
  localparam int unsigned IW = $clog2(THR + 1);
  localparam int unsigned DW = $clog2(DEF_CYC);

  logic [IW-1:0] integ_q, integ_nx;
  logic [DW-1:0] def_q, def_nx;
  logic          armed_q, armed_nx;
  logic          def_done;

  assign def_done = (def_q == DW'(DEF_CYC - 1));
  assign start    = armed_q & ~vs_busy & (rise | def_done);
  assign armed    = armed_q;

  always_comb begin
    integ_nx = integ_q;
    if (!lvl) begin
      if (integ_q != IW'(THR)) integ_nx = integ_q + IW'(1);
    end else if (integ_q != '0) begin
      integ_nx = integ_q - IW'(1);
    end

    armed_nx = armed_q;
    def_nx   = def_q;
    if (start) begin
      armed_nx = 1'b0;
      def_nx   = '0;
    end else if (armed_q) begin
      def_nx = def_q + DW'(1);
    end else if (!lvl && integ_q == IW'(THR - 1) && !vs_busy) begin
      armed_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      def_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      integ_q <= integ_nx;
      def_q   <= def_nx;
      armed_q <= armed_nx;
    end
  end
endmodule

// File: rtl/vfd_line_phase.sv
module vfd_line_phase #(
  parameter int unsigned LINE_CYC = 64,
  parameter int unsigned HS_MIN   = 4,
  parameter int unsigned THR      = 12,
  parameter int unsigned LOS_CYC  = 294
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lvl,
  input  logic                        rise,
  output logic [$clog2(LINE_CYC)-1:0] phase,
  output logic                        lost
);
  localparam int unsigned PW = $clog2(LINE_CYC);
  localparam int unsigned LW = $clog2(LOS_CYC + 1);

  logic [LW-1:0] low_q, low_nx;
  logic [PW-1:0] ph_q, ph_nx;
  logic          lost_q, lost_nx;
  logic          resync;

  assign resync = rise & (low_q >= LW'(HS_MIN)) & (low_q < LW'(THR));

  always_comb begin
    if (lvl)                       low_nx = '0;
    else if (low_q == LW'(LOS_CYC)) low_nx = low_q;
    else                           low_nx = low_q + LW'(1);

    if (resync)                          ph_nx = PW'(low_q) + PW'(1);
    else if (ph_q == PW'(LINE_CYC - 1))  ph_nx = '0;
    else                                 ph_nx = ph_q + PW'(1);

    if (lvl) lost_nx = 1'b0;
    else     lost_nx = lost_q | (low_q == LW'(LOS_CYC - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      ph_q   <= '0;
      lost_q <= 1'b0;
    end else begin
      low_q  <= low_nx;
      ph_q   <= ph_nx;
      lost_q <= lost_nx;
    end
  end

  assign phase = ph_q;
  assign lost  = lost_q;
endmodule

// File: rtl/vfd_vtimer.sv
module vfd_vtimer
  import vfd_pkg::*;
#(
  parameter int unsigned LINE_CYC = 64,
  parameter int unsigned VS_CYC   = 230
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(LINE_CYC)-1:0] phase,
  output logic                        vs_busy,
  output logic                        vsync_n,
  output logic                        field_odd
);
  localparam int unsigned CW = $clog2(VS_CYC);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          act_q, act_nx;
  field_e        fld_q, fld_nx;

  always_comb begin
    cnt_nx = cnt_q;
    act_nx = act_q;
    fld_nx = fld_q;
    if (start) begin
      act_nx = 1'b1;
      cnt_nx = CW'(VS_CYC - 1);
      fld_nx = classify_phase(32'(phase), LINE_CYC);
    end else if (act_q) begin
      if (cnt_q == '0) act_nx = 1'b0;
      else             cnt_nx = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      fld_q <= FIELD_EVEN;
    end else begin
      cnt_q <= cnt_nx;
      act_q <= act_nx;
      fld_q <= fld_nx;
    end
  end

  assign vs_busy   = act_q;
  assign vsync_n   = ~act_q;
  assign field_odd = fld_q;
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int unsigned LINE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n_in,
  output logic vsync_n,
  output logic field_odd,
  output logic signal_lost
);
  localparam int unsigned THR     = LINE_CYC * 3 / 16;
  localparam int unsigned HS_MIN  = LINE_CYC / 16;
  localparam int unsigned DEF_CYC = LINE_CYC * 55 / 64;
  localparam int unsigned VS_CYC  = LINE_CYC * 230 / 64;
  localparam int unsigned LOS_CYC = VS_CYC + LINE_CYC;
  localparam int unsigned PW      = $clog2(LINE_CYC);

  logic          lvl_w, rise_w, fall_w;
  logic          arm_w, start_w, busy_w;
  logic [PW-1:0] phase_w;

  vfd_sync_edge u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (csync_n_in),
    .lvl  (lvl_w),
    .rise (rise_w),
    .fall (fall_w)
  );

  vfd_integrator #(.THR(THR), .DEF_CYC(DEF_CYC)) u_integ (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (lvl_w),
    .rise   (rise_w),
    .vs_busy(busy_w),
    .armed  (arm_w),
    .start  (start_w)
  );

  vfd_line_phase #(
    .LINE_CYC(LINE_CYC), .HS_MIN(HS_MIN), .THR(THR), .LOS_CYC(LOS_CYC)
  ) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl_w),
    .rise (rise_w),
    .phase(phase_w),
    .lost (signal_lost)
  );

  vfd_vtimer #(.LINE_CYC(LINE_CYC), .VS_CYC(VS_CYC)) u_vtim (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .phase    (phase_w),
    .vs_busy  (busy_w),
    .vsync_n  (vsync_n),
    .field_odd(field_odd)
  );
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int unsigned VS_CYC = 230
) (
  input logic clk,
  input logic rst_n,
  input logic vsync_n,
  input logic field_odd,
  input logic signal_lost,
  input logic armed,
  input logic sync_lvl,
  input logic fall_seen
);
  int unsigned lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_cnt <= 0;
    else if (!vsync_n) lo_cnt <= lo_cnt + 1;
    else               lo_cnt <= 0;
  end

  // R5 / R9: never longer than the self-timed width
  assert_vs_width_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> lo_cnt < VS_CYC);

  // R5: every pulse ends at exactly the programmed width
  assert_vs_width_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> lo_cnt == VS_CYC);

  // R6: field flag moves only with the vertical leading edge
  assert_field_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_odd) |-> $fell(vsync_n));

  // R3: a vertical start needs an armed integrator
  assert_start_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(armed));

  // R8: loss flag only while the synchronized input was low
  assert_lost_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    signal_lost |-> !$past(sync_lvl));

  // R3: arming follows a low input
  assert_arm_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(sync_lvl));

  // R8: a synchronized falling edge is never seen with the loss flag already up
  assert_fall_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_seen |-> !signal_lost);
endmodule

bind vsync_field_det vfd_checker #(.VS_CYC(VS_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync_n    (vsync_n),
  .field_odd  (field_odd),
  .signal_lost(signal_lost),
  .armed      (arm_w),
  .sync_lvl   (lvl_w),
  .fall_seen  (fall_w)
);

// File: tb/vsync_field_det_bench.sv
module vsync_field_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 64;
  localparam int THR  = LINE * 3 / 16;
  localparam int DEF  = LINE * 55 / 64;
  localparam int VS   = LINE * 230 / 64;
  localparam int LOS  = VS + LINE;

  // vectors: mode (0 serration, 1 fallback), half-line pulses, expected odd, expected delay
  localparam int NVEC = 5;
  localparam int V_MODE [NVEC] = '{0, 0, 1, 1, 0};
  localparam int V_NEQ  [NVEC] = '{2, 3, 2, 3, 3};
  localparam int V_ODD  [NVEC] = '{0, 1, 1, 0, 1};
  localparam int V_DLY  [NVEC] = '{3, 3, THR + DEF + 2, THR + DEF + 2, 3};

  logic clk, rst_n, csync;
  logic vsync_n, field_odd, signal_lost;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int n_falls = 0, fall_cyc = 0, lo_w = 0, last_w = 0;
  int lost_rise_cyc = 0, lost_fall_cyc = 0;
  logic prev_v = 1'b1, prev_l = 1'b0;
  bit done = 0;

  vsync_field_det #(.LINE_CYC(LINE)) u_vsync_field_det (
    .clk(clk), .rst_n(rst_n), .csync_n_in(csync),
    .vsync_n(vsync_n), .field_odd(field_odd), .signal_lost(signal_lost)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && !vsync_n) begin fall_cyc = cyc; n_falls++; end
      if (!vsync_n) lo_w++;
      if (!prev_v && vsync_n) begin last_w = lo_w; lo_w = 0; end
      if (!prev_l && signal_lost) lost_rise_cyc = cyc;
      if (prev_l && !signal_lost) lost_fall_cyc = cyc;
      prev_v = vsync_n;
      prev_l = signal_lost;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lv, input int n);
    csync = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input int n, input int w);
    for (int k = 0; k < n; k++) begin hold(1'b0, w); hold(1'b1, LINE - w); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0, t;
    rst_n = 1'b0;
    csync = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(vsync_n == 1'b1, "R1", vsync_n, 1);
    chk(field_odd == 1'b0, "R1", field_odd, 0);
    chk(signal_lost == 1'b0, "R1", signal_lost, 0);

    for (int i = 0; i < NVEC; i++) begin
      int pf;
      pf = field_odd;
      f0 = n_falls;
      lines(4, 5);
      for (int e = 0; e < V_NEQ[i]; e++) begin hold(1'b0, 2); hold(1'b1, LINE / 2 - 2); end
      chk(n_falls == f0, "R2", n_falls - f0, 0);
      if (V_MODE[i] == 0) begin
        for (int b = 0; b < 3; b++) begin
          hold(1'b0, LINE / 2 - 5);
          if (b == 0) begin
            t = cyc;
            chk(field_odd == pf[0], "R6", field_odd, pf);
          end
          hold(1'b1, 5);
        end
      end else begin
        t = cyc;
        hold(1'b0, 100);
      end
      hold(1'b1, 300);
      chk(fall_cyc - t == V_DLY[i], (V_MODE[i] == 0) ? "R3" : "R4", fall_cyc - t, V_DLY[i]);
      chk(field_odd == V_ODD[i][0], "R6 R7", field_odd, V_ODD[i]);
      chk(last_w == VS, "R5", last_w, VS);
      chk(n_falls == f0 + 1, "R9", n_falls - f0, 1);
    end

    // R2 boundary: longest short pulse never arms
    f0 = n_falls;
    lines(10, THR - 1);
    hold(1'b1, 50);
    chk(n_falls == f0, "R2", n_falls - f0, 0);
    chk(vsync_n == 1'b1, "R2", vsync_n, 1);

    // R3 boundary: exactly THR low cycles arms, rise starts vertical
    hold(1'b0, THR);
    t = cyc;
    hold(1'b1, 300);
    chk(fall_cyc - t == 3, "R3", fall_cyc - t, 3);
    chk(n_falls == f0 + 1, "R3", n_falls - f0, 1);

    // R8 loss of signal
    t = cyc;
    hold(1'b0, LOS + 100);
    chk(signal_lost == 1'b1, "R8", signal_lost, 1);
    chk(lost_rise_cyc - t == LOS + 2, "R8", lost_rise_cyc - t, LOS + 2);
    t = cyc;
    hold(1'b1, 10);
    chk(lost_fall_cyc - t == 3, "R8", lost_fall_cyc - t, 3);
    chk(signal_lost == 1'b0, "R8", signal_lost, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule